// File: doc/BRIEF.md
# Serial EEPROM slave with two-wire bus interface

This block is a byte-wide non-volatile memory model that answers on a two-wire I2C bus as a slave. A fast system clock oversamples the bus. SCL and SDA pass through synchronisers, and the block detects bus edges, Start and Stop on the synchronised copies. It pulls SDA low through an open-drain enable and never drives the line high. The array is an internal register file of `MEM_BYTES` bytes, a power of two from 128 to 2048.

A master can do the following:
- address the device through a select byte;
- write one byte, or several bytes within one 16-byte page;
- read at a random address, at the current address, or as a sequential stream.

Written bytes are first collected in a page buffer. They reach the array only during a timed busy period that starts at a correctly placed Stop, and the block ignores the bus while that period runs. A write-lock input stops data bytes from being accepted. At sizes above 256 bytes, the low chip-enable bits of the select byte become upper address bits. Bit 1 carries address bit 8, bit 2 carries address bit 9 and bit 3 carries address bit 10, as the size requires.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, SDA is released, the busy flag is low, the address counter is 0, and every array byte reads FFh.
- R2: The select byte is taken MSB first. Bits 7:4 must be 1010, bits 3:1 must equal `chip_en_i[2:1:0]`, and bit 0 is the direction (1 = read, 0 = write). On a match, the slave pulls SDA low in the 9th clock. On a mismatch it gives no acknowledge and ignores every later byte until the next Start.
- R3: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. A Start in the middle of a byte restarts the select phase, and data bits are sampled on the SCL rising edge, MSB first.
- R4: A byte write is a write select, an address byte and one data byte, each acknowledged, followed by a Stop. The byte reaches the array only during the busy period that the Stop starts.
- R5: In a page write, only the low 4 address bits advance after each data byte. A write that runs past the end of a 16-byte page wraps to the start of the same page.
- R6: The busy period starts only for a Stop that comes right after the acknowledge of a data byte. A Stop in the middle of a byte, or a repeated Start, discards the pending write.
- R7: After a committing Stop, `busy_o` stays high for exactly `WRITE_CYCLES` clocks. While it is high, SDA is never driven and a select byte gets no acknowledge.
- R8: If `wr_lock_i` is high at any time from Start to the end of the address byte, the select and address bytes are still acknowledged. Data bytes are then not acknowledged, no busy period starts, and the array keeps its contents.
- R9: A random read is a write select, then an address byte, then a repeated Start and a read select. It returns the byte at that address, whatever the level of `wr_lock_i`.
- R10: Each byte read advances the full address counter. A current-address read continues from the counter, and a sequential read wraps from the last address to 00h.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing on later clocks until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| chip_en_i | input | 3 | Device address straps compared against select bits 3:1 |
| wr_lock_i | input | 1 | Write lock; high refuses data bytes of writes |
| busy_o | output | 1 | High during the internal write period |

## Verification
The bench goes after the wrap points. A page write that starts three bytes before a page end must land its last bytes at the page start, not in the next page; a design that increments the whole address would corrupt the neighbouring page. A read stream that crosses the last address must restart at 00h.

A Stop placed in the middle of a byte and a write cut off by a repeated Start are both sent. A design that commits on any Stop would raise busy and change the array. A write sent with the lock high is also covered: an implementation that refused the select byte, or still wrote the data, would show the wrong acknowledge or the wrong read-back. Finally, a select is sent while busy is high, and a design that answered during that period would acknowledge it.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEV   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_WDATA = 3'd3,
    ST_RDATA = 3'd4
  } ctrl_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[SYNC_STAGES-1];
  assign sda_s = sda_ff[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int AW           = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 400,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int BW = AW - PW,
  localparam int CW = $clog2(WRITE_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          cap_en_i,
  input  logic [AW-1:0] cap_addr_i,
  input  logic [7:0]    cap_data_i,
  input  logic          commit_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [7:0]    mem_wdata_o
);
  logic [7:0]            buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [BW-1:0]         base_q;
  logic [CW-1:0]         cnt_q;
  logic [PW-1:0]         idx_q;
  logic                  flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'h00;
      vld_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (commit_i) begin
        cnt_q   <= CW'(WRITE_CYCLES);
        idx_q   <= '0;
        flush_q <= 1'b1;
      end else if (flush_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == PW'(PAGE_BYTES - 1)) begin
          flush_q <= 1'b0;
          vld_q   <= '0;
        end
      end else if (clr_i) begin
        vld_q <= '0;
      end else if (cap_en_i) begin
        buf_q[cap_addr_i[PW-1:0]] <= cap_data_i;
        vld_q[cap_addr_i[PW-1:0]] <= 1'b1;
        base_q                    <= cap_addr_i[AW-1:PW];
      end
    end
  end

  assign busy_o      = cnt_q != '0;
  assign mem_we_o    = flush_q & vld_q[idx_q];
  assign mem_waddr_o = {base_q, idx_q};
  assign mem_wdata_o = buf_q[idx_q];
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 4,
  localparam int XB = (AW > 8) ? AW - 8 : 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [2:0]    chip_en_i,
  input  logic          wr_lock_i,
  input  logic          busy_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          sda_oe_o,
  output logic          clr_o,
  output logic          cap_en_o,
  output logic          commit_o
);
  ctrl_state_e   state_q;
  logic [3:0]    bit_cnt_q;
  logic          ack_ph_q, ack_q, tx_q, wp_q, armed_q, mack_q, rw_q;
  logic [7:0]    shreg_q, out_sh_q;
  logic [AW-1:0] addr_q, full_addr;
  logic [2:0]    ce_mask;
  logic          byte_done, dev_match, dev_accept, live;

  always_comb begin
    for (int i = 0; i < 3; i++) ce_mask[i] = (i >= XB);
  end

  assign live       = !busy_i && !start_i && !stop_i;
  assign byte_done  = !ack_ph_q && (bit_cnt_q == 4'd8);
  assign dev_match  = (shreg_q[7:4] == DEV_TYPE) &&
                      (((shreg_q[3:1] ^ chip_en_i) & ce_mask) == 3'b000);
  assign dev_accept = live && scl_fall_i && byte_done && (state_q == ST_DEV) && dev_match;

  generate
    if (XB > 0) begin : g_blk
      logic [XB-1:0] blk_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) blk_q <= '0;
        else if (dev_accept) blk_q <= shreg_q[XB:1];
      end
      assign full_addr = {blk_q, shreg_q};
    end else begin : g_flat
      assign full_addr = shreg_q[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      ack_q     <= 1'b0;
      tx_q      <= 1'b0;
      wp_q      <= 1'b0;
      armed_q   <= 1'b0;
      mack_q    <= 1'b1;
      rw_q      <= 1'b0;
      shreg_q   <= '0;
      out_sh_q  <= '0;
      addr_q    <= '0;
    end else if (busy_i) begin
      state_q  <= ST_IDLE;
      ack_ph_q <= 1'b0;
      ack_q    <= 1'b0;
      tx_q     <= 1'b0;
      armed_q  <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      ack_q     <= 1'b0;
      tx_q      <= 1'b0;
      armed_q   <= 1'b0;
      wp_q      <= wr_lock_i;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      ack_ph_q <= 1'b0;
      ack_q    <= 1'b0;
      tx_q     <= 1'b0;
      armed_q  <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (state_q == ST_DEV || state_q == ST_ADDR) wp_q <= wp_q | wr_lock_i;
      if (scl_rise_i) begin
        if (ack_ph_q) begin
          mack_q <= sda_i;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (state_q != ST_RDATA) shreg_q <= {shreg_q[6:0], sda_i};
        end
      end
      if (scl_fall_i) begin
        armed_q <= 1'b0;
        if (byte_done) begin
          bit_cnt_q <= '0;
          ack_ph_q  <= 1'b1;
          case (state_q)
            ST_DEV: begin
              ack_q <= dev_match;
              rw_q  <= shreg_q[0];
              if (!dev_match) state_q <= ST_IDLE;
            end
            ST_ADDR: begin
              ack_q  <= 1'b1;
              addr_q <= full_addr;
            end
            ST_WDATA: begin
              ack_q <= !wp_q;
              if (!wp_q) addr_q[PW-1:0] <= addr_q[PW-1:0] + 1'b1;
            end
            default: begin
              tx_q   <= 1'b0;
              addr_q <= addr_q + 1'b1;
            end
          endcase
        end else if (ack_ph_q) begin
          ack_ph_q <= 1'b0;
          ack_q    <= 1'b0;
          case (state_q)
            ST_DEV: begin
              if (rw_q) begin
                state_q  <= ST_RDATA;
                tx_q     <= 1'b1;
                out_sh_q <= rdata_i;
              end else begin
                state_q <= ST_ADDR;
              end
            end
            ST_ADDR:  state_q <= ST_WDATA;
            ST_WDATA: armed_q <= !wp_q;
            default: begin
              if (mack_q) begin
                state_q <= ST_IDLE;
              end else begin
                tx_q     <= 1'b1;
                out_sh_q <= rdata_i;
              end
            end
          endcase
        end else if (tx_q) begin
          out_sh_q <= {out_sh_q[6:0], 1'b0};
        end
      end
    end
  end

  assign addr_o   = addr_q;
  assign sda_oe_o = ack_q | (tx_q & ~out_sh_q[7]);
  assign clr_o    = live && scl_fall_i && byte_done && (state_q == ST_ADDR);
  assign cap_en_o = live && scl_fall_i && byte_done && (state_q == ST_WDATA) && !wp_q;
  assign commit_o = !busy_i && stop_i && armed_q;
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 400,
  parameter int SYNC_STAGES  = 2,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] chip_en_i,
  input  logic       wr_lock_i,
  output logic       busy_o
);
  logic          sda_s, scl_rise, scl_fall, start_w, stop_w;
  logic          clr_w, cap_w, commit_w, mem_we_w;
  logic [AW-1:0] addr_w, waddr_w;
  logic [7:0]    rdata_w, wdata_w, cap_data_w;

  eeprom_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w)
  );

  eeprom_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_w), .stop_i(stop_w),
    .chip_en_i, .wr_lock_i, .busy_i(busy_o), .rdata_i(rdata_w),
    .addr_o(addr_w), .sda_oe_o, .clr_o(clr_w), .cap_en_o(cap_w), .commit_o(commit_w)
  );

  // captured byte is the shift register content at byte end
  assign cap_data_w = u_ctrl.shreg_q;

  eeprom_page_buf #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_page (
    .clk_i, .rst_ni, .clr_i(clr_w), .cap_en_i(cap_w), .cap_addr_i(addr_w),
    .cap_data_i(cap_data_w), .commit_i(commit_w), .busy_o,
    .mem_we_o(mem_we_w), .mem_waddr_o(waddr_w), .mem_wdata_o(wdata_w)
  );

  eeprom_array #(.DEPTH(MEM_BYTES)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we_w), .waddr_i(waddr_w), .wdata_i(wdata_w),
    .raddr_i(addr_w), .rdata_o(rdata_w)
  );
endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk #(
  parameter int WRITE_CYCLES = 400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic sda_oe_i,
  input logic stop_i,
  input logic mem_we_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else if (busy_i) run_q <= run_q + 1;
    else run_q <= 0;
  end

  p_quiet_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i);

  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> run_q == WRITE_CYCLES);

  p_busy_after_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i));

  p_write_in_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> busy_i);
endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_o), .sda_oe_i(sda_oe_o),
  .stop_i(stop_w), .mem_we_i(mem_we_w)
);

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
  localparam int MEM_BYTES = 256;
  localparam int WCYC      = 300;
  localparam int Q         = 6;
  localparam logic [2:0] CE = 3'b101;
  localparam logic [7:0] WSEL = {4'b1010, CE, 1'b0};
  localparam logic [7:0] RSEL = {4'b1010, CE, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, lock = 1'b0;
  logic [2:0] ce = CE;
  logic sda_oe, busy;
  wire  sda_bus = sda_m & ~sda_oe;

  serial_eeprom_slave #(.MEM_BYTES(MEM_BYTES), .WRITE_CYCLES(WCYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .chip_en_i(ce), .wr_lock_i(lock), .busy_o(busy)
  );

  always #5 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int busy_run = 0, last_len = 0;
  logic [7:0] exp_mem [MEM_BYTES];

  always @(negedge clk) begin
    if (busy) busy_run++;
    else if (busy_run != 0) begin
      last_len = busy_run;
      busy_run = 0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = !sda_bus; tick(Q);
    scl_m = 1'b0;
  endtask

  task automatic recv(input bit m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_bus; tick(Q);
      scl_m = 1'b0;
    end
    sda_m = m_ack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0;
  endtask

  task automatic wait_ready();
    while (busy) tick(1);
    tick(4);
  endtask

  // page write with 4-bit wrap in the model
  task automatic write_page(input logic [7:0] a, input int n, input logic [7:0] seed, input string req);
    bit ak;
    logic [7:0] d;
    logic [3:0] lo;
    bus_start();
    send(WSEL, ak); check(ak, req, ak, 1);
    send(a, ak);    check(ak, req, ak, 1);
    for (int k = 0; k < n; k++) begin
      d  = seed + 8'(k * 37);
      lo = a[3:0] + 4'(k);
      send(d, ak); check(ak, req, ak, 1);
      exp_mem[{a[7:4], lo}] = d;
    end
    bus_stop();
    check(busy == 1'b1, "R7", busy, 1);
    wait_ready();
    check(last_len == WCYC, "R7", last_len, WCYC);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    bit ak;
    logic [7:0] d;
    logic [7:0] ea;
    bus_start();
    send(WSEL, ak); check(ak, "R9", ak, 1);
    send(a, ak);    check(ak, "R9", ak, 1);
    bus_start();
    send(RSEL, ak); check(ak, "R9", ak, 1);
    for (int k = 0; k < n; k++) begin
      recv(k != n - 1, d);
      ea = a + 8'(k);
      check(d == exp_mem[ea], req, d, exp_mem[ea]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    bit ak;
    logic [7:0] d;
    for (int i = 0; i < MEM_BYTES; i++) exp_mem[i] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    check(sda_oe == 1'b0, "R1", sda_oe, 0);
    check(busy == 1'b0, "R1", busy, 0);

    // R1 and R10: current-address stream from 0 over the whole array and past the end
    bus_start();
    send(RSEL, ak); check(ak, "R2", ak, 1);
    for (int k = 0; k <= MEM_BYTES; k++) begin
      recv(k != MEM_BYTES, d);
      check(d == 8'hFF, "R1", d, 8'hFF);
    end
    bus_stop();

    // R2 chip-enable sweep; a mismatch ignores the following byte
    for (int c = 0; c < 8; c++) begin
      bus_start();
      send({4'b1010, 3'(c), 1'b0}, ak);
      check(ak == (3'(c) == CE), "R2", ak, (3'(c) == CE));
      if (!ak) begin
        send(WSEL, ak);
        check(!ak, "R2", ak, 0);
      end
      bus_stop();
    end
    for (int t = 0; t < 16; t++) begin
      if (t != 10) begin
        bus_start();
        send({4'(t), CE, 1'b1}, ak);
        check(!ak, "R2", ak, 0);
        bus_stop();
      end
    end

    // R3 Start inside a byte restarts the select phase
    bus_start();
    send_bits(8'hC3, 4);
    bus_start();
    send(WSEL, ak); check(ak, "R3", ak, 1);
    bus_stop();

    // R4 byte write, R7 no answer while busy
    bus_start();
    send(WSEL, ak); check(ak, "R4", ak, 1);
    send(8'h3A, ak); check(ak, "R4", ak, 1);
    send(8'h5C, ak); check(ak, "R4", ak, 1);
    exp_mem[8'h3A] = 8'h5C;
    bus_stop();
    check(busy == 1'b1, "R7", busy, 1);
    bus_start();
    send(WSEL, ak); check(!ak, "R7", ak, 0);
    bus_stop();
    wait_ready();
    check(last_len == WCYC, "R7", last_len, WCYC);
    rand_read(8'h3A, 1, "R4");

    // R5 page write wrapping inside the page, neighbour page untouched
    write_page(8'h7D, 5, 8'h11, "R5");
    rand_read(8'h70, 17, "R5");

    // R10 wrap of a sequential read and current-address continuation
    write_page(8'hFF, 1, 8'hA5, "R10");
    write_page(8'h00, 2, 8'h3C, "R10");
    rand_read(8'hFE, 3, "R10");
    bus_start();
    send(RSEL, ak); check(ak, "R10", ak, 1);
    recv(1'b0, d);
    check(d == exp_mem[8'h01], "R10", d, exp_mem[8'h01]);
    bus_stop();

    // R8 write lock: select and address acked, data refused, array unchanged
    lock = 1'b1;
    bus_start();
    send(WSEL, ak); check(ak, "R8", ak, 1);
    send(8'h40, ak); check(ak, "R8", ak, 1);
    send(8'h99, ak); check(!ak, "R8", ak, 0);
    bus_stop();
    tick(4);
    check(busy == 1'b0, "R8", busy, 0);
    rand_read(8'h40, 1, "R8");
    rand_read(8'h3A, 1, "R9");
    lock = 1'b0;

    // R6 Stop mid-byte and repeated Start do not commit
    bus_start();
    send(WSEL, ak); send(8'h50, ak);
    send(8'h77, ak); check(ak, "R6", ak, 1);
    send_bits(8'hFF, 3);
    bus_stop();
    tick(4);
    check(busy == 1'b0, "R6", busy, 0);
    bus_start();
    send(WSEL, ak); send(8'h51, ak);
    send(8'h66, ak); check(ak, "R6", ak, 1);
    bus_start();
    send(RSEL, ak); check(ak, "R6", ak, 1);
    check(busy == 1'b0, "R6", busy, 0);
    recv(1'b0, d);
    check(d == exp_mem[8'h52], "R6", d, exp_mem[8'h52]);
    bus_stop();
    rand_read(8'h50, 2, "R6");

    // R11 after a master NoAck the slave stays off the bus
    bus_start();
    send(RSEL, ak); check(ak, "R11", ak, 1);
    recv(1'b0, d);
    for (int i = 0; i < 9; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      check(sda_bus == 1'b1 && sda_oe == 1'b0, "R11", sda_oe, 0);
      tick(Q);
      scl_m = 1'b0;
    end
    bus_stop();

    tick(10);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule